// File: doc/BRIEF.md
# Three-Wire Serial Slave Protocol Engine

This block is the slave side of a three-wire serial bus. The bus has an enable line, a serial clock and a single data line that both sides drive in turn. The block watches the bus with a faster system clock. Each bus line passes through a synchronizer, and the block finds the clock and enable edges in the system clock domain. A transfer opens with an eight-bit command byte, sent least significant bit first. The command selects clock space or RAM space, a five-bit address, and a direction. It also says whether writes are allowed at all.

After the command, the block moves data bytes in or out. It turns each completed byte into a one-cycle request to a register bank next to it. A write request carries the address, the space and the byte. A read request expects the bank to return the byte on `rd_data` in the same system cycle. The data pad is modelled as an output value plus an output enable.

Address 31 selects burst mode. In burst mode the transfer starts at address 0 and moves one address per byte, up to the last address of the selected space. The block also gives a pulse when a transaction starts and another when it ends.

Top module: `tw_slave`

## Requirements
- R1: A rising enable gives one `txn_start` pulse, and a falling enable gives one `txn_end` pulse. While enable is low, `dio_oe` stays 0, and dropping enable in the middle of a read releases the line.
- R2: Command bits are taken on rising serial clock edges, bit 0 first. Bit 0 = 1 means read and 0 means write. Bits 5:1 are the address. Bit 6 = 1 selects RAM space and 0 selects clock space. Bit 7 = 1 allows writes.
- R3: A single-byte write gives exactly one `req_wr`, with the address, the space and the data byte taken LSB first. Any further serial clocks in the same transaction give no more writes.
- R4: If command bit 7 is 0, no write request is made, and the addressed location keeps its old value when it is read back.
- R5: A single-byte read gives `req_rd` for the commanded address. Bit 0 of the returned byte is driven after the falling edge that follows the last command bit, and the bits go out LSB first. Extra serial clocks send the same byte again while enable stays high.
- R6: During a read, `dio_oe` goes to 0 after every rising serial clock edge, and `dio_oe` is 1 only in the read phase.
- R7: Address 31 selects burst mode. The transfer starts at address 0 and the address goes up by one for each byte, for both reads and writes.
- R8: A burst write ends at address 7 in clock space and at address 30 in RAM space. Bytes after that give no write requests.
- R9: A burst read that runs past the last address keeps reading the last address.
- R10: `req_wr` and `req_rd` are never high together, and each write request lasts one cycle.
- R11: If enable drops while a data byte is only partly received, no write is made for that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Bus enable line (asynchronous) |
| sclk_i | input | 1 | Bus serial clock (asynchronous) |
| dio_i | input | 1 | Bus data line as seen at the pad input |
| rd_data | input | 8 | Byte from the register bank, valid in the cycle `req_rd` is high |
| dio_o | output | 1 | Value driven onto the data line |
| dio_oe | output | 1 | Output enable for the data pad |
| req_wr | output | 1 | One-cycle write request |
| req_rd | output | 1 | One-cycle read request |
| req_ram | output | 1 | Space select for the request: 1 = RAM, 0 = clock |
| req_addr | output | 5 | Request address |
| req_wdata | output | 8 | Write data byte |
| txn_start | output | 1 | Pulse when a transaction starts |
| txn_end | output | 1 | Pulse when a transaction ends |

## Verification
The assertions assume three things about the bus. The serial clock is low when enable rises. The data line stays stable around each rising serial clock edge for longer than the synchronizer delay. Each serial clock phase lasts longer than the synchronizer plus edge-detect delay, so one system cycle never shows a rising and a falling edge together. The stimulus holds each serial clock phase for six system cycles. It changes the data only while the serial clock is low, and it raises enable only while the serial clock is low. The bench's register bank answers each read request in the same cycle, as the read path expects.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int CMD_W  = 8;
  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD, PH_DONE} phase_t;

  typedef struct packed {
    logic              wr_ok;
    logic              ram;
    logic              burst;
    logic [ADDR_W-1:0] addr;
    logic              rd;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] b);
    cmd_t c;
    c.wr_ok = b[CMD_W-1];
    c.ram   = b[CMD_W-2];
    c.addr  = b[ADDR_W:1];
    c.burst = &b[ADDR_W:1];
    c.rd    = b[0];
    return c;
  endfunction

  function automatic logic [ADDR_W-1:0] first_addr(input cmd_t c);
    return c.burst ? '0 : c.addr;
  endfunction

  function automatic logic [ADDR_W-1:0] space_last(input logic ram,
      input logic [ADDR_W-1:0] clk_last, input logic [ADDR_W-1:0] ram_last);
    return ram ? ram_last : clk_last;
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] cur,
      input logic [ADDR_W-1:0] last);
    return (cur == last) ? cur : ADDR_W'(cur + 1'b1);
  endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= '0;
      else        st <= {st[STAGES-2:0], d[b]};
    end
    assign q[b] = st[STAGES-1];
  end
endmodule

// File: rtl/tw_edge.sv
module tw_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= s;
  end
  assign rise = s & ~prev;
  assign fall = ~s & prev;
endmodule

// File: rtl/tw_xfer.sv
module tw_xfer import tw_pkg::*; #(
  parameter int CLK_LAST = 7,
  parameter int RAM_LAST = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              din_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic [CMD_W-1:0]  rd_data,
  output logic              req_wr,
  output logic              req_rd,
  output logic              req_ram,
  output logic [ADDR_W-1:0] req_addr,
  output logic [CMD_W-1:0]  req_wdata,
  output logic              dio_o,
  output logic              dio_oe
);
  localparam int BCW = $clog2(CMD_W);
  localparam logic [ADDR_W-1:0] CL = ADDR_W'(CLK_LAST);
  localparam logic [ADDR_W-1:0] RL = ADDR_W'(RAM_LAST);
  localparam logic [BCW-1:0] TOP_BIT = BCW'(CMD_W - 1);

  phase_t            phase;
  logic [CMD_W-2:0]  sh;
  logic [BCW-1:0]    bitcnt, ocnt;
  logic              c_ram, c_burst, c_wr_ok;
  logic [ADDR_W-1:0] addr;
  logic [CMD_W-1:0]  rbuf;

  logic [CMD_W-1:0]  byte_in;
  cmd_t              cmd_new;
  logic [ADDR_W-1:0] last, nxt;
  logic              byte_done, cmd_done, rd_first, rd_next, wr_fire;

  assign byte_in   = {din_s, sh};
  assign cmd_new   = decode_cmd(byte_in);
  assign last      = space_last(c_ram, CL, RL);
  assign nxt       = step_addr(addr, last);
  assign byte_done = sclk_rise && (bitcnt == TOP_BIT);
  assign cmd_done  = ce_s && (phase == PH_CMD) && byte_done;
  assign rd_first  = cmd_done && cmd_new.rd;
  assign rd_next   = ce_s && (phase == PH_RD) && sclk_fall && (ocnt == TOP_BIT) && c_burst;
  assign wr_fire   = ce_s && (phase == PH_WR) && byte_done && c_wr_ok;

  assign req_rd    = rd_first || rd_next;
  assign req_wr    = wr_fire;
  assign req_ram   = rd_first ? cmd_new.ram : c_ram;
  assign req_addr  = rd_first ? first_addr(cmd_new) : (rd_next ? nxt : addr);
  assign req_wdata = byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CMD;
      sh      <= '0;
      bitcnt  <= '0;
      ocnt    <= '0;
      c_ram   <= 1'b0;
      c_burst <= 1'b0;
      c_wr_ok <= 1'b0;
      addr    <= '0;
      rbuf    <= '0;
      dio_o   <= 1'b0;
      dio_oe  <= 1'b0;
    end else if (!ce_s) begin
      phase  <= PH_CMD;
      bitcnt <= '0;
      ocnt   <= '0;
      dio_o  <= 1'b0;
      dio_oe <= 1'b0;
    end else begin
      if (sclk_rise) begin
        dio_oe <= 1'b0;
        if (phase inside {PH_CMD, PH_WR}) begin
          sh     <= byte_in[CMD_W-1:1];
          bitcnt <= bitcnt + 1'b1;
        end
        if (cmd_done) begin
          c_ram   <= cmd_new.ram;
          c_burst <= cmd_new.burst;
          c_wr_ok <= cmd_new.wr_ok;
          addr    <= first_addr(cmd_new);
          if (cmd_new.rd) begin
            phase <= PH_RD;
            rbuf  <= rd_data;
            ocnt  <= '0;
          end else begin
            phase <= PH_WR;
          end
        end
        if (phase == PH_WR && byte_done) begin
          if (c_burst && addr != last) addr  <= nxt;
          else                         phase <= PH_DONE;
        end
      end
      if (sclk_fall && phase == PH_RD) begin
        dio_o  <= rbuf[ocnt];
        dio_oe <= 1'b1;
        ocnt   <= ocnt + 1'b1;
        if (rd_next) begin
          addr <= nxt;
          rbuf <= rd_data;
        end
      end
    end
  end

  // R10: the two request strobes are exclusive
  a_r10_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_wr && req_rd));
  // R10: a write request lasts one cycle
  a_r10_wr_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr |=> !req_wr);
  // R8: writes stay inside the selected space
  a_r8_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr |-> (req_ram ? (req_addr <= RL) : (req_addr <= CL)));
  // R6: the line is released after each rising serial clock
  a_r6_release_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !dio_oe);
  // R6: the line is driven only during the read phase
  a_r6_oe_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
    dio_oe |-> (phase == PH_RD));
  // R1: enable low forces idle and a released line
  a_r1_idle_when_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> (!dio_oe && phase == PH_CMD));
endmodule

// File: rtl/tw_slave.sv
module tw_slave import tw_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int CLK_LAST    = 7,
  parameter int RAM_LAST    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              sclk_i,
  input  logic              dio_i,
  input  logic [CMD_W-1:0]  rd_data,
  output logic              dio_o,
  output logic              dio_oe,
  output logic              req_wr,
  output logic              req_rd,
  output logic              req_ram,
  output logic [ADDR_W-1:0] req_addr,
  output logic [CMD_W-1:0]  req_wdata,
  output logic              txn_start,
  output logic              txn_end
);
  logic [2:0] pins_q;
  logic       ce_s, sclk_s, din_s;
  logic [1:0] rise, fall;

  tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({dio_i, sclk_i, ce_i}), .q(pins_q));
  assign {din_s, sclk_s, ce_s} = pins_q;

  tw_edge #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .s({sclk_s, ce_s}), .rise(rise), .fall(fall));

  assign txn_start = rise[0];
  assign txn_end   = fall[0];

  tw_xfer #(.CLK_LAST(CLK_LAST), .RAM_LAST(RAM_LAST)) u_xfer (
    .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .din_s(din_s),
    .sclk_rise(rise[1]), .sclk_fall(fall[1]), .rd_data(rd_data),
    .req_wr(req_wr), .req_rd(req_rd), .req_ram(req_ram),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .dio_o(dio_o), .dio_oe(dio_oe));

  // R1: the serial clock is low whenever a transaction opens
  a_r1_sclk_low_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    rise[0] |-> !sclk_s);
  // R1: start and end pulses never coincide
  a_r1_start_end_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(txn_start && txn_end));
endmodule

// File: tb/sim_tw_slave.sv
module sim_tw_slave;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0;
  logic ce = 0, sclk = 0, dio_in = 0;
  logic [7:0] rd_data;
  logic dio_o, dio_oe, req_wr, req_rd, req_ram, txn_start, txn_end;
  logic [4:0] req_addr;
  logic [7:0] req_wdata;

  int n_chk = 0, n_fail = 0, n_start = 0, n_end = 0, n_sess = 0, ce_low_run = 0;
  logic [13:0] exp_wr[$];
  logic [13:0] e_front;
  logic [7:0] bclk[8], bram[31];
  logic [7:0] mdl_clk[8], mdl_ram[31];

  always #4 clk = ~clk;

  tw_slave u0 (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .dio_i(dio_in),
    .rd_data(rd_data), .dio_o(dio_o), .dio_oe(dio_oe), .req_wr(req_wr),
    .req_rd(req_rd), .req_ram(req_ram), .req_addr(req_addr),
    .req_wdata(req_wdata), .txn_start(txn_start), .txn_end(txn_end));

  // register bank beside the engine
  always_comb begin
    if (req_ram) rd_data = (req_addr < 5'd31) ? bram[req_addr] : 8'h00;
    else         rd_data = (req_addr < 5'd8) ? bclk[req_addr[2:0]] : 8'h00;
  end
  always @(posedge clk) begin
    if (req_wr) begin
      if (req_ram && req_addr < 5'd31) bram[req_addr] <= req_wdata;
      if (!req_ram && req_addr < 5'd8) bclk[req_addr[2:0]] <= req_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (rst_n) begin
      if (req_wr) begin
        if (exp_wr.size() == 0)
          chk(0, "R3", "unexpected write", int'({req_ram, req_addr, req_wdata}), 0);
        else begin
          e_front = exp_wr.pop_front();
          chk({req_ram, req_addr, req_wdata} == e_front, "R3", "write request",
              int'({req_ram, req_addr, req_wdata}), int'(e_front));
        end
      end
      if (req_wr && req_rd) chk(0, "R10", "both requests", 3, 0);
      if (txn_start) n_start++;
      if (txn_end) n_end++;
      ce_low_run = ce ? 0 : ce_low_run + 1;
      if (ce_low_run > 4 && dio_oe) chk(0, "R1", "driven while enable low", 1, 0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_open();
    ce = 1; n_sess++; tick(HALF);
  endtask

  task automatic bus_close();
    tick(HALF); ce = 0; tick(2 * HALF);
  endtask

  task automatic put_bit(input bit b);
    dio_in = b; tick(HALF); sclk = 1; tick(HALF); sclk = 0;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_bit(v[i]);
  endtask

  task automatic get_bits(input logic [7:0] e, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      tick(HALF);
      chk(dio_oe === 1'b1 && dio_o === e[i], req, "read bit",
          int'({dio_oe, dio_o}), int'({1'b1, e[i]}));
      sclk = 1;
      tick(HALF);
      chk(dio_oe === 1'b0, "R6", "release after rise", int'(dio_oe), 0);
      sclk = 0;
    end
  endtask

  task automatic expect_write(input bit ram, input int a, input logic [7:0] d);
    exp_wr.push_back({ram, 5'(a), d});
    if (ram) mdl_ram[a] = d; else mdl_clk[a] = d;
  endtask

  task automatic queue_empty(input string req);
    tick(4);
    chk(exp_wr.size() == 0, req, "missing writes", exp_wr.size(), 0);
    exp_wr.delete();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin bclk[i] = 8'h10 + 8'(i); mdl_clk[i] = 8'h10 + 8'(i); end
    for (int i = 0; i < 31; i++) begin bram[i] = 8'hA0 ^ 8'(i); mdl_ram[i] = 8'hA0 ^ 8'(i); end
    tick(5);
    rst_n = 1;
    tick(3);
    // R1: reset state
    chk(dio_oe == 0 && req_wr == 0 && req_rd == 0 && txn_start == 0, "R1", "reset outputs",
        int'({dio_oe, req_wr, req_rd, txn_start}), 0);

    // R2 R3: single clock write, addr 3 (cmd 0x86), then extra clocks ignored
    expect_write(0, 3, 8'h5A);
    bus_open(); put_byte(8'h86); put_byte(8'h5A); put_byte(8'hFF); bus_close();
    queue_empty("R3");

    // R2 R3: single RAM write, addr 17 (cmd 0xE2)
    expect_write(1, 17, 8'hC3);
    bus_open(); put_byte(8'hE2); put_byte(8'hC3); bus_close();
    queue_empty("R3");

    // R4: bit 7 clear blocks the write (cmd 0x06)
    bus_open(); put_byte(8'h06); put_byte(8'hFF); bus_close();
    queue_empty("R4");
    bus_open(); put_byte(8'h87); get_bits(mdl_clk[3], 8, "R4"); bus_close();

    // R5: single read clock addr 3, extra clocks resend
    bus_open(); put_byte(8'h87); get_bits(mdl_clk[3], 8, "R5");
    get_bits(mdl_clk[3], 8, "R5"); bus_close();
    // R5: single read RAM addr 17 (cmd 0xE3)
    bus_open(); put_byte(8'hE3); get_bits(mdl_ram[17], 8, "R5"); bus_close();

    // R7 R8: clock burst write (cmd 0xBE), two bytes past the end
    for (int i = 0; i < 8; i++) expect_write(0, i, 8'h20 + 8'(i));
    bus_open(); put_byte(8'hBE);
    for (int i = 0; i < 10; i++) put_byte(8'h20 + 8'(i));
    bus_close();
    queue_empty("R8");

    // R7 R9: clock burst read (cmd 0xBF), one byte past the end
    bus_open(); put_byte(8'hBF);
    for (int i = 0; i < 8; i++) get_bits(mdl_clk[i], 8, "R7");
    get_bits(mdl_clk[7], 8, "R9");
    bus_close();

    // R7 R8: RAM burst write (cmd 0xFE), one byte past the end
    for (int i = 0; i < 31; i++) expect_write(1, i, 8'h3C ^ 8'(i * 7));
    bus_open(); put_byte(8'hFE);
    for (int i = 0; i < 32; i++) put_byte(8'h3C ^ 8'(i * 7));
    bus_close();
    queue_empty("R8");

    // R7 R9: RAM burst read (cmd 0xFF)
    bus_open(); put_byte(8'hFF);
    for (int i = 0; i < 31; i++) get_bits(mdl_ram[i], 8, "R7");
    get_bits(mdl_ram[30], 8, "R9");
    bus_close();

    // R11: partial data byte then enable drops (cmd 0x8A, addr 5)
    bus_open(); put_byte(8'h8A);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    ce = 0; tick(2 * HALF);
    queue_empty("R11");
    bus_open(); put_byte(8'h8B); get_bits(mdl_clk[5], 8, "R11"); bus_close();

    // R1: enable drops in the middle of a read
    bus_open(); put_byte(8'h8B); get_bits(mdl_clk[5], 3, "R5");
    ce = 0; tick(HALF);
    chk(dio_oe === 1'b0, "R1", "release on abort", int'(dio_oe), 0);
    tick(HALF);

    chk(n_start == n_sess, "R1", "start pulses", n_start, n_sess);
    chk(n_end == n_sess, "R1", "end pulses", n_end, n_sess);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule